// File: doc/BRIEF.md
# SD/MMC Command Admission Gate

This block sits between the host-side command registers and the card command engine of an SD/MMC controller. Each time software strobes a new command request, the gate decides whether the request may go to the card. The decision depends on the transfer already running and on the extra rules for CE-ATA devices. It answers one cycle later with either an accept pulse or a reject pulse. A reject pulse comes with a 3-bit reason code. The gate also reports whether a data transfer is open and whether a CE-ATA completion signal is still outstanding.

The tracking is a three-state machine:

- `ST_IDLE`: no transfer is open.
- `ST_XFER`: one data transfer is open.
- `ST_CCS`: a CE-ATA block command was issued with device interrupts enabled, and the gate is waiting for its completion signal.

The state transitions are:

- `ST_IDLE -> ST_XFER`: a data command is accepted.
- `ST_IDLE -> ST_CCS`: a CE-ATA block command is accepted while device interrupts are enabled.
- `ST_XFER -> ST_IDLE`: transfer done, an accepted stop command, or an accepted card reset that carries the abort flag.
- `ST_CCS -> ST_IDLE`: completion signal seen, or an accepted completion-signal-disable command.

Command indices are decoded by the gate itself:

| Command | Index |
|---|---|
| Status read | 13 |
| Stop | 12 |
| CE-ATA completion-signal-disable | 12, sent to a CE-ATA target |
| CE-ATA block read/write | 61 |
| Card reset | 0, 15 and 52 |

Top module: `sdcmd_gate`

## Requirements
- R1: While the synchronous reset `rst` is high and in the cycle after it, accept, reject, reason, busy and ccs_wait are all 0.
- R2: A request sampled at a clock edge produces exactly one one-cycle pulse, on accept or on reject, visible after that edge. With no request, neither pulse is raised. Accept and reject are never high together. The reason code is 0 whenever reject is low.
- R3: In ST_IDLE any request that passes the CE-ATA flag checks is accepted. A request with the data flag set makes busy go to 1.
- R4: In ST_XFER a request without the data flag for index 13 (status) or 12 (stop) is accepted. An accepted stop ends the transfer, so busy returns to 0. Any other non-data, non-reset request is rejected with reason 1 (busy).
- R5: In ST_XFER a request with the data flag set is rejected with reason 2 (second data command). This holds for index 13 as well.
- R6: In ST_XFER a card reset request (index 0, 15 or 52) with the abort flag set is accepted and busy returns to 0. Without the abort flag it is rejected with reason 3.
- R7: A CE-ATA request for index 61 with the data flag, while device interrupts are enabled (`irq_off`=0), is accepted and raises ccs_wait. While ccs_wait is high, every request except index 12 to a CE-ATA target is rejected with reason 4, including a further index-61 command. Index 12 to a CE-ATA target is accepted and clears ccs_wait and busy.
- R8: With device interrupts disabled (`irq_off`=1), an accepted CE-ATA index-61 data command opens an ordinary transfer with ccs_wait 0. A CE-ATA status read (index 13) is then accepted.
- R9: A CE-ATA request with the open-ended flag set is rejected with reason 5 in every state. This check has priority over all other checks.
- R10: A CE-ATA request with the auto-stop flag set and the open-ended flag clear is rejected with reason 6 in every state. A request that is not for a CE-ATA target may carry either flag.
- R11: A `xfer_done` pulse returns ST_XFER to idle, and is ignored in ST_CCS. A `ccs_seen` pulse returns ST_CCS to idle, and is ignored in ST_XFER. A request arriving in the same cycle as `xfer_done` is judged against the state before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle command request strobe |
| req_index | input | 6 | Command index |
| req_data | input | 1 | Command expects a data transfer |
| req_open | input | 1 | Open-ended transfer request |
| req_autostop | input | 1 | Automatic stop requested |
| req_abort | input | 1 | Stop/abort flag for reset commands |
| req_ceata | input | 1 | Request targets a CE-ATA device |
| irq_off | input | 1 | CE-ATA device interrupts disabled (1) or enabled (0) |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse |
| ccs_seen | input | 1 | One-cycle completion-signal-received pulse |
| accept | output | 1 | Request admitted, one cycle |
| reject | output | 1 | Request refused, one cycle |
| reason | output | 3 | Reject reason code: 1 to 6, 0 when reject is low |
| busy | output | 1 | A transfer or completion wait is open |
| ccs_wait | output | 1 | Waiting for the CE-ATA completion signal |

## Verification
A wrong state register shows up on the very next request. A gate stuck in ST_IDLE accepts commands that should get reason 1 or 2. A gate that leaves ST_CCS too early accepts a status read that should get reason 4. A missed transition also shows one cycle after the causing pulse on busy or ccs_wait. The bench therefore reads busy and ccs_wait after every request and every done or completion pulse, not only at the end of each scenario. Errors in reason priority show only when several flags are set at once, so the CE-ATA scenarios combine open-ended and auto-stop flags with pending states.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CCS  = 2'd2
    } gate_state_t;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_BUSY    = 3'd1,
        RSN_DATA    = 3'd2,
        RSN_NOABORT = 3'd3,
        RSN_CEPEND  = 3'd4,
        RSN_CEOPEN  = 3'd5,
        RSN_CEAUTO  = 3'd6
    } reason_t;

    typedef struct packed {
        logic is_status;
        logic is_stop;
        logic is_reset;
        logic is_rwblk;
        logic is_ccsd;
    } cmd_kind_t;

endpackage

// File: rtl/sdcmd_classify.sv
module sdcmd_classify
    import sdcmd_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int IDX_STATUS = 13,
    parameter int IDX_STOP   = 12,
    parameter int IDX_RWBLK  = 61,
    parameter int IDX_CCSD   = 12,
    parameter int RESET_CNT  = 3,
    parameter logic [RESET_CNT*IDX_W-1:0] RESET_LIST = {6'd52, 6'd15, 6'd0}
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             ceata,
    output cmd_kind_t        kind
);
    localparam logic [IDX_W-1:0] K_STATUS = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] K_STOP   = IDX_W'(IDX_STOP);
    localparam logic [IDX_W-1:0] K_RWBLK  = IDX_W'(IDX_RWBLK);
    localparam logic [IDX_W-1:0] K_CCSD   = IDX_W'(IDX_CCSD);

    logic [RESET_CNT-1:0] reset_hit;

    // One comparator for each card-reset index in the list.
    genvar g;
    generate
        for (g = 0; g < RESET_CNT; g++) begin : g_rst
            assign reset_hit[g] = (idx == RESET_LIST[g*IDX_W +: IDX_W]);
        end
    endgenerate

    always_comb begin
        kind.is_status = (idx == K_STATUS);
        kind.is_stop   = (idx == K_STOP);
        kind.is_reset  = |reset_hit;
        kind.is_rwblk  = ceata && (idx == K_RWBLK);
        kind.is_ccsd   = ceata && (idx == K_CCSD);
    end
endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
    import sdcmd_pkg::*;
(
    input  gate_state_t state,
    input  cmd_kind_t   kind,
    input  logic        req_data,
    input  logic        req_open,
    input  logic        req_autostop,
    input  logic        req_abort,
    input  logic        req_ceata,
    output logic        ok,
    output reason_t     why
);
    always_comb begin
        ok  = 1'b0;
        why = RSN_NONE;
        // The CE-ATA flag checks apply in every state and come first.
        if (req_ceata && req_open) begin
            why = RSN_CEOPEN;
        end else if (req_ceata && req_autostop) begin
            why = RSN_CEAUTO;
        end else begin
            unique case (state)
                ST_IDLE: ok = 1'b1;
                ST_XFER: begin
                    if (kind.is_reset) begin
                        if (req_abort) ok  = 1'b1;
                        else           why = RSN_NOABORT;
                    end else if (req_data) begin
                        why = RSN_DATA;
                    end else if (kind.is_status || kind.is_stop) begin
                        ok = 1'b1;
                    end else begin
                        why = RSN_BUSY;
                    end
                end
                ST_CCS: begin
                    if (kind.is_ccsd) ok  = 1'b1;
                    else              why = RSN_CEPEND;
                end
                default: why = RSN_BUSY;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_gate.sv
module sdcmd_gate
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_data,
    input  logic             req_open,
    input  logic             req_autostop,
    input  logic             req_abort,
    input  logic             req_ceata,
    input  logic             irq_off,
    input  logic             xfer_done,
    input  logic             ccs_seen,
    output logic             accept,
    output logic             reject,
    output logic [2:0]       reason,
    output logic             busy,
    output logic             ccs_wait
);
    gate_state_t state, state_nx;
    cmd_kind_t   kind;
    logic        ok;
    reason_t     why;
    logic        take;

    sdcmd_classify #(.IDX_W(IDX_W)) u_cls (
        .idx   (req_index),
        .ceata (req_ceata),
        .kind  (kind)
    );

    sdcmd_rules u_rules (
        .state        (state),
        .kind         (kind),
        .req_data     (req_data),
        .req_open     (req_open),
        .req_autostop (req_autostop),
        .req_abort    (req_abort),
        .req_ceata    (req_ceata),
        .ok           (ok),
        .why          (why)
    );

    assign take = req_valid && ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take && req_data) begin
                    if (kind.is_rwblk && !irq_off) state_nx = ST_CCS;
                    else                           state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_done || (take && (kind.is_stop || kind.is_reset)))
                    state_nx = ST_IDLE;
            end
            ST_CCS: begin
                if (ccs_seen || (take && kind.is_ccsd))
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            accept <= 1'b0;
            reject <= 1'b0;
            reason <= 3'd0;
        end else begin
            accept <= take;
            reject <= req_valid && !ok;
            reason <= (req_valid && !ok) ? 3'(why) : 3'd0;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign ccs_wait = (state == ST_CCS);
endmodule

// File: rtl/sdcmd_gate_check.sv
module sdcmd_gate_check (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_data,
    input logic       req_open,
    input logic       req_ceata,
    input logic       irq_off,
    input logic       xfer_done,
    input logic       ccs_seen,
    input logic       accept,
    input logic       reject,
    input logic [2:0] reason,
    input logic       busy,
    input logic       ccs_wait
);
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(accept && reject));

    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (rst)
        (accept || reject) |-> $past(req_valid));

    assert_reason_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !reject |-> (reason == 3'd0));

    assert_reason_set_R2: assert property (@(posedge clk) disable iff (rst)
        reject |-> (reason != 3'd0));

    assert_ccs_busy_R7: assert property (@(posedge clk) disable iff (rst)
        ccs_wait |-> busy);

    assert_ccs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ccs_wait) |-> $past(req_valid && req_ceata && req_data && !irq_off));

    assert_open_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (reject && reason == 3'd5) |-> $past(req_ceata && req_open));

    assert_idle_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(xfer_done || ccs_seen || req_valid));
endmodule

bind sdcmd_gate sdcmd_gate_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_data  (req_data),
    .req_open  (req_open),
    .req_ceata (req_ceata),
    .irq_off   (irq_off),
    .xfer_done (xfer_done),
    .ccs_seen  (ccs_seen),
    .accept    (accept),
    .reject    (reject),
    .reason    (reason),
    .busy      (busy),
    .ccs_wait  (ccs_wait)
);

// File: tb/sdcmd_gate_test.sv
module sdcmd_gate_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_data = 0, req_open = 0, req_autostop = 0;
    logic       req_abort = 0, req_ceata = 0, irq_off = 0;
    logic       xfer_done = 0, ccs_seen = 0;
    logic [5:0] req_index = 0;
    logic       accept, reject, busy, ccs_wait;
    logic [2:0] reason;
    int         checks = 0, failures = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    sdcmd_gate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_data(req_data), .req_open(req_open), .req_autostop(req_autostop),
        .req_abort(req_abort), .req_ceata(req_ceata), .irq_off(irq_off),
        .xfer_done(xfer_done), .ccs_seen(ccs_seen), .accept(accept),
        .reject(reject), .reason(reason), .busy(busy), .ccs_wait(ccs_wait)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request and check the result pulse plus status one cycle later.
    task automatic issue(input int idx, input bit d, input bit op, input bit au,
                         input bit ab, input bit ce, input bit with_done,
                         input bit exp_acc, input int exp_rsn,
                         input bit exp_busy, input bit exp_ccs, input string tag);
        @(negedge clk);
        req_valid = 1; req_index = 6'(idx); req_data = d; req_open = op;
        req_autostop = au; req_abort = ab; req_ceata = ce; xfer_done = with_done;
        @(negedge clk);
        req_valid = 0; req_data = 0; req_open = 0; req_autostop = 0;
        req_abort = 0; req_ceata = 0; xfer_done = 0;
        chk(!(accept && reject), {tag, " R2 exclusive"}, int'(accept & reject), 0);
        chk(accept == exp_acc, {tag, " accept"}, accept, exp_acc);
        chk(reject == !exp_acc, {tag, " reject"}, reject, !exp_acc);
        chk(reason == 3'(exp_rsn), {tag, " reason"}, reason, exp_rsn);
        chk(busy == exp_busy, {tag, " busy"}, busy, exp_busy);
        chk(ccs_wait == exp_ccs, {tag, " ccs_wait"}, ccs_wait, exp_ccs);
    endtask

    task automatic pulse(input bit done, input bit ccs, input bit exp_busy,
                         input bit exp_ccs, input string tag);
        @(negedge clk);
        xfer_done = done; ccs_seen = ccs;
        @(negedge clk);
        xfer_done = 0; ccs_seen = 0;
        chk(!accept && !reject, {tag, " R2 no pulse"}, int'(accept | reject), 0);
        chk(busy == exp_busy, {tag, " busy"}, busy, exp_busy);
        chk(ccs_wait == exp_ccs, {tag, " ccs_wait"}, ccs_wait, exp_ccs);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk({accept, reject, reason, busy, ccs_wait} == 7'd0, "R1 in reset",
            {accept, reject, reason, busy, ccs_wait}, 0);
        rst = 0;
        @(negedge clk);
        chk({accept, reject, reason, busy, ccs_wait} == 7'd0, "R1 after reset",
            {accept, reject, reason, busy, ccs_wait}, 0);
    endtask

    task automatic t_idle();
        issue(17, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 idle plain");
        pulse(0, 0, 0, 0, "R2 idle quiet");
        issue(18, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R3 idle data");
    endtask

    task automatic t_xfer();
        issue(6, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R4 busy reject");
        issue(13, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R4 status");
        issue(25, 1, 0, 0, 0, 0, 0, 0, 2, 1, 0, "R5 second data");
        issue(13, 1, 0, 0, 0, 0, 0, 0, 2, 1, 0, "R5 status with data");
        issue(12, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4 stop");
    endtask

    task automatic t_resets();
        issue(18, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R6 open");
        issue(0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, "R6 idle-reset no abort");
        issue(15, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R6 inactive with abort");
        issue(18, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R6 reopen");
        issue(52, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, "R6 cmd52 no abort");
        issue(52, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R6 cmd52 abort");
        issue(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 reset while idle");
    endtask

    task automatic t_done();
        issue(18, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R11 open");
        pulse(0, 1, 1, 0, "R11 ccs ignored in xfer");
        pulse(1, 0, 0, 0, "R11 done closes");
        issue(18, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R11 reopen");
        issue(6, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R11 request with done");
    endtask

    task automatic t_ceata_irq();
        irq_off = 0;
        issue(61, 1, 0, 0, 0, 1, 0, 1, 0, 1, 1, "R7 block start");
        issue(61, 1, 0, 0, 0, 1, 0, 0, 4, 1, 1, "R7 second block");
        issue(13, 0, 0, 0, 0, 1, 0, 0, 4, 1, 1, "R7 status pending");
        issue(12, 0, 0, 0, 0, 0, 0, 0, 4, 1, 1, "R7 stop non-ceata");
        issue(61, 1, 1, 0, 0, 1, 0, 0, 5, 1, 1, "R9 open while pending");
        pulse(1, 0, 1, 1, "R11 done ignored in ccs");
        pulse(0, 1, 0, 0, "R11 ccs closes");
        issue(61, 1, 0, 0, 0, 1, 0, 1, 0, 1, 1, "R7 block again");
        issue(12, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R7 ccsd");
    endtask

    task automatic t_ceata_nien();
        irq_off = 1;
        issue(61, 1, 0, 0, 0, 1, 0, 1, 0, 1, 0, "R8 block no irq");
        issue(13, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0, "R8 status accepted");
        pulse(1, 0, 0, 0, "R8 done");
        irq_off = 0;
    endtask

    task automatic t_ceata_flags();
        issue(18, 1, 1, 0, 0, 1, 0, 0, 5, 0, 0, "R9 open idle");
        issue(18, 1, 0, 1, 0, 1, 0, 0, 6, 0, 0, "R10 autostop idle");
        issue(18, 1, 1, 1, 0, 1, 0, 0, 5, 0, 0, "R9 both flags");
        issue(18, 1, 1, 1, 0, 0, 0, 1, 0, 1, 0, "R10 flags non-ceata");
        issue(25, 1, 0, 1, 0, 1, 0, 0, 6, 1, 0, "R10 autostop over data");
        pulse(1, 0, 0, 0, "R11 close");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_xfer();
        t_resets();
        t_done();
        t_ceata_irq();
        t_ceata_nien();
        t_ceata_flags();
        t_reset();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule